// File: doc/BRIEF.md
# CRTC Timing Generator With Offsets

This block produces the raster timing for a character-clocked display controller. It runs on a clock that ticks once per 8-pixel character. A character counter sweeps each scan line and a line counter sweeps each frame. From these counters and a set of programmed values it drives horizontal and vertical sync, horizontal and vertical blanking, and a display-enable strobe.

The programmed values arrive in the biased encoding that software writes into the register file. The horizontal total is stored minus five, and its ninth bit sits in a separate field. The vertical total is stored minus two and is assembled to 12 bits from a low byte and a high nibble. The last displayed character and the last displayed line are each stored minus one. The sync-end fields keep only a few low bits, so the generator compares them modulo. In interlaced mode the vertical total, sync start and sync end are halved, while the vertical display end is left alone. Software is expected to change the programming only while the block is held in reset.

Top module: `crtc_timing`

## Requirements
- R1: While reset is low, and in the first cycle after it, both counters read 0 and hsync, hblank and vsync are low.
- R2: The character counter counts 0, 1, … up to H-1 and then returns to 0, where H = {h_total_hi, h_total_lo} + 5. This includes the case where the ninth field bit is set.
- R3: With D = h_disp_last + 1, a character counts as horizontally visible when the character counter is below D.
- R4: hblank goes high when the character counter reaches D. It goes low at the count whose low 6 bits equal H-1, provided the blank window is shorter than 64 characters. As a result, hblank is low at counts H-1 and 0.
- R5: hsync goes high when the character counter equals h_sync_begin. It goes low at the first later count whose low 5 bits equal h_sync_stop, for pulses of 1 to 31 characters.
- R6: The line counter advances only when the character counter wraps from H-1 to 0. It returns to 0 after line V-1, where V = {v_total_hi, v_total_lo} + 2, or V = ({v_total_hi, v_total_lo} + 2) >> 1 when interlace is high.
- R7: vblank is high exactly when the line counter is at least v_disp_last + 1. This threshold is the same whether or not interlace is set.
- R8: vsync goes high at the line equal to S, where S = v_sync_begin, or v_sync_begin >> 1 when interlaced. It stays high for the following lines until the end match. In non-interlaced mode the end match is line[3:0] == v_sync_stop. In interlaced mode it is line[2:0] == v_sync_stop[3:1], which is the halved end value. Pulses must be shorter than 16 lines, or shorter than 8 when interlaced.
- R9: disp_en is high exactly when the character is horizontally visible (R3) and vblank is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_total_lo | input | 8 | Horizontal total minus 5, bits 7:0 |
| h_total_hi | input | 1 | Horizontal total minus 5, bit 8 |
| h_disp_last | input | 8 | Visible characters minus 1 |
| h_sync_begin | input | 8 | Character count where hsync starts |
| h_sync_stop | input | 5 | Low 5 bits of the count where hsync ends |
| v_total_lo | input | 8 | Vertical total minus 2, bits 7:0 |
| v_total_hi | input | 4 | Vertical total minus 2, bits 11:8 |
| v_disp_last | input | 12 | Visible lines minus 1 |
| v_sync_begin | input | 12 | Line where vsync starts (before halving) |
| v_sync_stop | input | 4 | Low 4 bits of the line where vsync ends (before halving) |
| interlace | input | 1 | Halve vertical total and sync positions |
| hsync | output | 1 | Horizontal sync, active high |
| hblank | output | 1 | Horizontal blanking |
| vsync | output | 1 | Vertical sync, active high |
| vblank | output | 1 | Vertical blanking |
| disp_en | output | 1 | Display enable |
| char_cnt | output | 10 | Character counter |
| line_cnt | output | 13 | Line counter |

## Verification
The assertions assume the programming inputs stay constant outside reset. They also assume that the display end and sync start lie inside the total, and that every sync and blank window is narrower than its compare field can alias. The stimulus therefore loads each configuration only while reset is held. It picks sync starts, widths and display ends from ranges that respect those bounds, including the interlaced vertical sync width limit of 8 lines. The sweep covers interlaced and non-interlaced frames, several horizontal totals and sync widths, and totals that set the ninth horizontal bit and the high vertical nibble.

// File: rtl/crtc_timing.sv
module crtc_timing #(
  parameter int HW = 9,
  parameter int VW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    h_total_lo,
  input  logic [HW-9:0] h_total_hi,
  input  logic [7:0]    h_disp_last,
  input  logic [7:0]    h_sync_begin,
  input  logic [4:0]    h_sync_stop,
  input  logic [7:0]    v_total_lo,
  input  logic [VW-9:0] v_total_hi,
  input  logic [VW-1:0] v_disp_last,
  input  logic [VW-1:0] v_sync_begin,
  input  logic [3:0]    v_sync_stop,
  input  logic          interlace,
  output logic          hsync,
  output logic          hblank,
  output logic          vsync,
  output logic          vblank,
  output logic          disp_en,
  output logic [HW:0]   char_cnt,
  output logic [VW:0]   line_cnt
);
  localparam int CW = HW + 1;
  localparam int LW = VW + 1;

  logic [CW-1:0] h_last, h_disp, hc_nx;
  logic [LW-1:0] v_tot_raw, v_tot, v_last, v_disp, vs_eff, vc_nx;
  logic          h_wrap, v_wrap, v_end_hit;
  logic          hsync_q, hblank_q, vsync_q;

  assign h_last = CW'({h_total_hi, h_total_lo}) + CW'(4);
  assign h_disp = CW'(h_disp_last) + CW'(1);
  assign h_wrap = (char_cnt == h_last);
  assign hc_nx  = h_wrap ? '0 : char_cnt + CW'(1);

  assign v_tot_raw = LW'({v_total_hi, v_total_lo}) + LW'(2);
  assign v_tot     = interlace ? (v_tot_raw >> 1) : v_tot_raw;
  assign v_last    = v_tot - LW'(1);
  assign v_disp    = LW'(v_disp_last) + LW'(1);
  assign vs_eff    = interlace ? LW'(v_sync_begin >> 1) : LW'(v_sync_begin);
  assign v_wrap    = (line_cnt == v_last);
  assign vc_nx     = h_wrap ? (v_wrap ? '0 : line_cnt + LW'(1)) : line_cnt;
  assign v_end_hit = interlace ? (vc_nx[2:0] == v_sync_stop[3:1])
                               : (vc_nx[3:0] == v_sync_stop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      char_cnt <= '0;
      line_cnt <= '0;
      hsync_q  <= 1'b0;
      hblank_q <= 1'b0;
      vsync_q  <= 1'b0;
    end else begin
      char_cnt <= hc_nx;
      line_cnt <= vc_nx;
      if (hc_nx == CW'(h_sync_begin))     hsync_q <= 1'b1;
      else if (hc_nx[4:0] == h_sync_stop) hsync_q <= 1'b0;
      if (hc_nx == h_disp)                hblank_q <= 1'b1;
      else if (hc_nx[5:0] == h_last[5:0]) hblank_q <= 1'b0;
      if (h_wrap) begin
        if (vc_nx == vs_eff)              vsync_q <= 1'b1;
        else if (v_end_hit)               vsync_q <= 1'b0;
      end
    end
  end

  assign hsync   = hsync_q;
  assign hblank  = hblank_q;
  assign vsync   = vsync_q;
  assign vblank  = (line_cnt >= v_disp);
  assign disp_en = (char_cnt < h_disp) && !vblank;
endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] h_total_lo,
  input logic       h_total_hi,
  input logic [7:0] h_disp_last,
  input logic [7:0] h_sync_begin,
  input logic       hsync,
  input logic       hblank,
  input logic       vblank,
  input logic       disp_en,
  input logic [9:0] char_cnt,
  input logic [12:0] line_cnt
);
  logic [9:0] hl;
  assign hl = 10'({h_total_hi, h_total_lo}) + 10'd4;

  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    char_cnt <= hl);

  a_r2_wraps_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (char_cnt == hl) |=> (char_cnt == 10'd0));

  a_r6_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (char_cnt != hl) |=> $stable(line_cnt));

  a_r5_sync_rises_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync) |-> (char_cnt == 10'(h_sync_begin)));

  a_r4_blank_rises_at_disp_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hblank) |-> (char_cnt == 10'(h_disp_last) + 10'd1));

  a_r9_enable_not_blanked: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> (!hblank && !vblank));
endmodule

bind crtc_timing crtc_timing_chk u_chk (
  .clk(clk), .rst_n(rst_n), .h_total_lo(h_total_lo), .h_total_hi(h_total_hi),
  .h_disp_last(h_disp_last), .h_sync_begin(h_sync_begin), .hsync(hsync),
  .hblank(hblank), .vblank(vblank), .disp_en(disp_en),
  .char_cnt(char_cnt), .line_cnt(line_cnt)
);

// File: tb/tb_crtc_timing.sv
module tb_crtc_timing;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  h_total_lo = 8'd5, h_disp_last = 8'd3, h_sync_begin = 8'd5, v_total_lo = 8'd14;
  logic        h_total_hi = 1'b0, interlace = 1'b0;
  logic [4:0]  h_sync_stop = 5'd6;
  logic [3:0]  v_total_hi = 4'd0, v_sync_stop = 4'd12;
  logic [11:0] v_disp_last = 12'd4, v_sync_begin = 12'd10;
  logic hsync, hblank, vsync, vblank, disp_en;
  logic [9:0]  char_cnt;
  logic [12:0] line_cnt;
  int errors = 0, checks = 0, cycles = 0;

  always #2.5 clk = ~clk;

  crtc_timing dut (
    .clk(clk), .rst_n(rst_n), .h_total_lo(h_total_lo), .h_total_hi(h_total_hi),
    .h_disp_last(h_disp_last), .h_sync_begin(h_sync_begin), .h_sync_stop(h_sync_stop),
    .v_total_lo(v_total_lo), .v_total_hi(v_total_hi), .v_disp_last(v_disp_last),
    .v_sync_begin(v_sync_begin), .v_sync_stop(v_sync_stop), .interlace(interlace),
    .hsync(hsync), .hblank(hblank), .vsync(vsync), .vblank(vblank), .disp_en(disp_en),
    .char_cnt(char_cnt), .line_cnt(line_cnt)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (time %0t)", req, act, exp, $time);
    end
  endtask

  task automatic run_cfg(int hf, int hdl, int hsb, int hwid,
                         int vf, int vdl, int vsb, int vwid, int il);
    int H, D, V, VD, VS;
    H  = hf + 5;
    D  = hdl + 1;
    V  = il ? (vf + 2) >> 1 : vf + 2;
    VD = vdl + 1;
    VS = il ? vsb >> 1 : vsb;
    @(negedge clk);
    rst_n = 1'b0;
    h_total_lo = hf[7:0]; h_total_hi = hf[8];
    h_disp_last = hdl[7:0]; h_sync_begin = hsb[7:0];
    h_sync_stop = 5'((hsb + hwid) & 31);
    v_total_lo = vf[7:0]; v_total_hi = vf[11:8];
    v_disp_last = vdl[11:0]; v_sync_begin = vsb[11:0];
    v_sync_stop = il ? 4'(((VS + vwid) << 1) & 15) : 4'((VS + vwid) & 15);
    interlace = il[0];
    repeat (3) @(negedge clk);
    check("R1 char_cnt in reset", int'(char_cnt), 0);
    check("R1 line_cnt in reset", int'(line_cnt), 0);
    check("R1 hsync in reset", int'(hsync), 0);
    check("R1 hblank in reset", int'(hblank), 0);
    check("R1 vsync in reset", int'(vsync), 0);
    rst_n = 1'b1;
    for (int n = 0; n < 2 * H * V + 3; n++) begin
      int hc, vc;
      hc = n % H;
      vc = (n / H) % V;
      check("R2 char_cnt", int'(char_cnt), hc);
      check("R6 line_cnt", int'(line_cnt), vc);
      check("R4 hblank", int'(hblank), int'(hc >= D && hc < H - 1));
      check("R5 hsync", int'(hsync), int'(hc >= hsb && hc < hsb + hwid));
      check("R7 vblank", int'(vblank), int'(vc >= VD));
      check("R8 vsync", int'(vsync), int'(vc >= VS && vc < VS + vwid));
      check("R9 R3 disp_en", int'(disp_en), int'(hc < D && vc < VD));
      @(negedge clk);
    end
  endtask

  initial begin
    for (int ht = 0; ht < 3; ht++)
      for (int il = 0; il < 2; il++)
        for (int sw = 1; sw <= 3; sw++) begin
          int hf;
          hf = 10 + 3 * ht - 5;
          run_cfg(hf, (hf + 5) / 2 - 1, (hf + 5) / 2 + 1, sw,
                  14, 4 + il, 10, 1 + sw % 2, il);
        end
    // R2: ninth horizontal total bit set
    run_cfg(256, 199, 210, 3, 14, 4, 10, 2, 0);
    // R6: high vertical total nibble set
    run_cfg(5, 4, 6, 2, 256, 199, 250, 3, 0);
    // R8: interlaced, longest allowed vertical sync
    run_cfg(7, 5, 7, 4, 30, 10, 12, 7, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule